// File: doc/BRIEF.md
# Cartridge CPU-Side Bank Mapper

This block sits between a console CPU bus and the memories of a game cartridge. It turns CPU writes in the upper half of the address space into bank-select register loads. It also translates every CPU access into a program ROM address or a save-RAM address.

The CPU sees three windows:
- An 8 KB RAM window at `$6000-$7FFF`.
- A switchable 16 KB ROM window at `$8000-$BFFF`.
- A window at `$C000-$FFFF` that is always tied to the last 16 KB of the 256 KB ROM.

The block also holds four 5-bit character bank numbers and a nametable mirroring bit. A separate tile-triggered switcher consumes these values. That switcher, and the nametable wiring, are outside this block. The CPU never contends with ROM data on a write, so register loads take the bus data unmodified.

A register load happens on a rising clock edge while both `cpu_en` and `cpu_wr` are high. The register page is chosen by address bits `[15:12]`. Address and enable outputs are combinational from the CPU address and the current register contents.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the program bank, all four character banks and the mirroring bit read as zero. A read at `$8000` therefore gives ROM address `18'h00000`.
- R2: `ram_en` is high exactly when `cpu_en` is high and `cpu_addr[15:13]` equals `3'b011` (`$6000-$7FFF`), for both reads and writes. `ram_addr` equals `cpu_addr[12:0]`.
- R3: For a CPU read in `$8000-$BFFF`, `rom_addr` equals `{prg_bank, cpu_addr[13:0]}`, where `prg_bank` is the 4-bit program bank register.
- R4: For a CPU read in `$C000-$FFFF`, `rom_addr` equals `{4'hF, cpu_addr[13:0]}`, whatever the program bank holds.
- R5: A write anywhere in `$A000-$AFFF` loads `cpu_data[3:0]` into the program bank; `cpu_data[7:4]` are ignored.
- R6: A write loads `cpu_data[4:0]` into one character bank, chosen by the page; `cpu_data[7:5]` are ignored.
  - Page `$B` loads `chr_lo_a`.
  - Page `$C` loads `chr_lo_b`.
  - Page `$D` loads `chr_hi_a`.
  - Page `$E` loads `chr_hi_b`.
- R7: A write anywhere in `$F000-$FFFF` loads `cpu_data[0]` into `mirror_horiz`, where 1 means horizontal and 0 means vertical. The other data bits are ignored.
- R8: Writes to `$8000-$9FFF` or below `$8000` change no register.
- R9: `rom_en` is high exactly when `cpu_en` is high, `cpu_wr` is low and `cpu_addr[15]` is 1. It is low in every other case.
- R10: A register is loaded on the edge that samples the write, and its new value drives the outputs from that edge onward. When `cpu_en` or `cpu_wr` is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | High for a write, low for a read |
| cpu_en | input | 1 | Access valid this cycle |
| rom_addr | output | 18 | Program ROM address |
| rom_en | output | 1 | Program ROM read enable |
| ram_addr | output | 13 | Save-RAM address |
| ram_en | output | 1 | Save-RAM enable |
| chr_lo_a | output | 5 | Low pattern table bank, first switcher state |
| chr_lo_b | output | 5 | Low pattern table bank, second switcher state |
| chr_hi_a | output | 5 | High pattern table bank, first switcher state |
| chr_hi_b | output | 5 | High pattern table bank, second switcher state |
| mirror_horiz | output | 1 | Mirroring select: 1 horizontal, 0 vertical |

## Verification
The load checks assume that a write is a single-cycle pulse of `cpu_en` and `cpu_wr`, with the address and data held stable across the sampling edge. They also assume that inputs never carry X while `cpu_en` is high. The bench drives every input on the falling edge, holds it for one full cycle and returns `cpu_en` low between accesses. The assertions are disabled until the internally synchronised reset is released, and the bench issues its first write only after that point.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  localparam int CPU_AW     = 16;
  localparam int CPU_DW     = 8;
  localparam int PRG_BANK_W = 4;
  localparam int CHR_BANK_W = 5;
  localparam int ROM_WIN_W  = 14;
  localparam int RAM_AW     = 13;
  localparam int ROM_AW     = PRG_BANK_W + ROM_WIN_W;
  localparam int NUM_CHR    = 4;
  localparam int NUM_SLOTS  = NUM_CHR + 2;
  localparam int PAGE_W     = 4;

  // Register slot order follows the write page order starting at page $A.
  typedef enum logic [2:0] {
    SLOT_PRG    = 3'd0,
    SLOT_CHR_LA = 3'd1,
    SLOT_CHR_LB = 3'd2,
    SLOT_CHR_HA = 3'd3,
    SLOT_CHR_HB = 3'd4,
    SLOT_MIRROR = 3'd5
  } reg_slot_e;

  localparam logic [PAGE_W-1:0] FIRST_REG_PAGE = 4'hA;
endpackage

// File: rtl/cart_wr_decode.sv
module cart_wr_decode
  import cart_map_pkg::*;
#(
  parameter int PW     = PAGE_W,
  parameter int NSLOTS = NUM_SLOTS
) (
  input  logic [PW-1:0]     page,
  input  logic              cpu_wr,
  input  logic              cpu_en,
  output logic [NSLOTS-1:0] load
);
  logic fire;

  always_comb begin
    fire = cpu_en & cpu_wr;
  end

  for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
    localparam logic [PW-1:0] SLOT_PAGE = PW'(FIRST_REG_PAGE + i);
    always_comb begin
      load[i] = fire && (page == SLOT_PAGE);
    end
  end
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_map_pkg::*;
#(
  parameter int DW     = CPU_DW,
  parameter int PBW    = PRG_BANK_W,
  parameter int CBW    = CHR_BANK_W,
  parameter int NCHR   = NUM_CHR,
  parameter int NSLOTS = NUM_SLOTS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSLOTS-1:0]        load,
  input  logic [DW-1:0]            wr_data,
  output logic [PBW-1:0]           prg_bank,
  output logic [NCHR-1:0][CBW-1:0] chr_bank,
  output logic                     mirror
);
  logic [PBW-1:0]           prg_d;
  logic [PBW-1:0]           prg_q;
  logic [NCHR-1:0][CBW-1:0] chr_d;
  logic [NCHR-1:0][CBW-1:0] chr_q;
  logic                     mir_d;
  logic                     mir_q;
  logic                     unused_data_hi;

  always_comb begin
    unused_data_hi = ^wr_data[DW-1:CBW];
  end

  // Program bank and mirroring bit.
  always_comb begin
    prg_d = prg_q;
    mir_d = mir_q;
    if (load[SLOT_PRG])    prg_d = wr_data[PBW-1:0];
    if (load[SLOT_MIRROR]) mir_d = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg_q <= '0;
      mir_q <= 1'b0;
    end else begin
      if (load[SLOT_PRG])    prg_q <= prg_d;
      if (load[SLOT_MIRROR]) mir_q <= mir_d;
    end
  end

  // Character banks: one storage element per slot.
  for (genvar c = 0; c < NCHR; c++) begin : g_chr
    localparam int SL = int'(SLOT_CHR_LA) + c;

    always_comb begin
      chr_d[c] = load[SL] ? wr_data[CBW-1:0] : chr_q[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chr_q[c] <= '0;
      end else if (load[SL]) begin
        chr_q[c] <= chr_d[c];
      end
    end
  end

  always_comb begin
    prg_bank = prg_q;
    chr_bank = chr_q;
    mirror   = mir_q;
  end
endmodule

// File: rtl/cart_prg_xlat.sv
module cart_prg_xlat
  import cart_map_pkg::*;
#(
  parameter int AW  = CPU_AW,
  parameter int PBW = PRG_BANK_W,
  parameter int WW  = ROM_WIN_W,
  parameter int RW  = RAM_AW
) (
  input  logic [AW-1:0]     cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_en,
  input  logic [PBW-1:0]    prg_bank,
  output logic [PBW+WW-1:0] rom_addr,
  output logic              rom_en,
  output logic [RW-1:0]     ram_addr,
  output logic              ram_en
);
  localparam logic [PBW-1:0]     LAST_BANK = '1;
  localparam logic [AW-RW-1:0]   RAM_PAGE  = (AW-RW)'(3);

  logic [PBW-1:0] bank_sel;

  always_comb begin
    // Upper ROM window (address bit WW set) is pinned to the last bank.
    bank_sel = cpu_addr[WW] ? LAST_BANK : prg_bank;
    rom_addr = {bank_sel, cpu_addr[WW-1:0]};
    rom_en   = cpu_en & ~cpu_wr & cpu_addr[AW-1];
    ram_addr = cpu_addr[RW-1:0];
    ram_en   = cpu_en & (cpu_addr[AW-1:RW] == RAM_PAGE);
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_map_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CPU_AW-1:0]     cpu_addr,
  input  logic [CPU_DW-1:0]     cpu_data,
  input  logic                  cpu_wr,
  input  logic                  cpu_en,
  output logic [ROM_AW-1:0]     rom_addr,
  output logic                  rom_en,
  output logic [RAM_AW-1:0]     ram_addr,
  output logic                  ram_en,
  output logic [CHR_BANK_W-1:0] chr_lo_a,
  output logic [CHR_BANK_W-1:0] chr_lo_b,
  output logic [CHR_BANK_W-1:0] chr_hi_a,
  output logic [CHR_BANK_W-1:0] chr_hi_b,
  output logic                  mirror_horiz
);
  logic [1:0]                          rst_sync_q;
  logic                                rst_core_n;
  logic [NUM_SLOTS-1:0]                load;
  logic [PRG_BANK_W-1:0]               prg_bank;
  logic [NUM_CHR-1:0][CHR_BANK_W-1:0]  chr_bank;

  // Reset asserts at once and is released two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  always_comb begin
    rst_core_n = rst_sync_q[1];
  end

  cart_wr_decode u_dec (
    .page   (cpu_addr[CPU_AW-1 -: PAGE_W]),
    .cpu_wr (cpu_wr),
    .cpu_en (cpu_en),
    .load   (load)
  );

  cart_bank_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (load),
    .wr_data  (cpu_data),
    .prg_bank (prg_bank),
    .chr_bank (chr_bank),
    .mirror   (mirror_horiz)
  );

  cart_prg_xlat u_xlat (
    .cpu_addr (cpu_addr),
    .cpu_wr   (cpu_wr),
    .cpu_en   (cpu_en),
    .prg_bank (prg_bank),
    .rom_addr (rom_addr),
    .rom_en   (rom_en),
    .ram_addr (ram_addr),
    .ram_en   (ram_en)
  );

  always_comb begin
    chr_lo_a = chr_bank[0];
    chr_lo_b = chr_bank[1];
    chr_hi_a = chr_bank[2];
    chr_hi_b = chr_bank[3];
  end
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk
  import cart_map_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [CPU_AW-1:0]     cpu_addr,
  input logic [CPU_DW-1:0]     cpu_data,
  input logic                  cpu_wr,
  input logic                  cpu_en,
  input logic [ROM_AW-1:0]     rom_addr,
  input logic                  rom_en,
  input logic                  ram_en,
  input logic [CHR_BANK_W-1:0] chr_lo_a,
  input logic [CHR_BANK_W-1:0] chr_lo_b,
  input logic [CHR_BANK_W-1:0] chr_hi_a,
  input logic [CHR_BANK_W-1:0] chr_hi_b,
  input logic                  mirror_horiz
);
  logic wr_now;
  logic chr_page;

  always_comb begin
    wr_now   = cpu_en & cpu_wr;
    chr_page = (cpu_addr[15:12] >= 4'hB) && (cpu_addr[15:12] <= 4'hE);
  end

  assert_ram_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> (cpu_en && cpu_addr[15:13] == 3'b011));

  assert_fixed_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_en && cpu_addr[15:14] == 2'b11) |-> (rom_addr[17:14] == 4'hF));

  assert_prg_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_now && cpu_addr[15:12] == 4'hA) |=>
      (!(rom_en && cpu_addr[15:14] == 2'b10) ||
       rom_addr[17:14] == $past(cpu_data[3:0])));

  assert_mirror_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_now && cpu_addr[15:12] == 4'hF) |=> (mirror_horiz == $past(cpu_data[0])));

  assert_chr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_now && chr_page) |=>
      ($stable(chr_lo_a) && $stable(chr_lo_b) && $stable(chr_hi_a) && $stable(chr_hi_b)));

  assert_rom_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> (cpu_en && !cpu_wr && cpu_addr[15]));

  assert_mirror_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_now && cpu_addr[15:12] == 4'hF) |=> $stable(mirror_horiz));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .cpu_addr     (cpu_addr),
  .cpu_data     (cpu_data),
  .cpu_wr       (cpu_wr),
  .cpu_en       (cpu_en),
  .rom_addr     (rom_addr),
  .rom_en       (rom_en),
  .ram_en       (ram_en),
  .chr_lo_a     (chr_lo_a),
  .chr_lo_b     (chr_lo_b),
  .chr_hi_a     (chr_hi_a),
  .chr_hi_b     (chr_hi_b),
  .mirror_horiz (mirror_horiz)
);

// File: tb/cart_bank_mapper_bench.sv
module cart_bank_mapper_bench;
  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic        cpu_wr;
  logic        cpu_en;
  logic [17:0] rom_addr;
  logic        rom_en;
  logic [12:0] ram_addr;
  logic        ram_en;
  logic [4:0]  chr_lo_a, chr_lo_b, chr_hi_a, chr_hi_b;
  logic        mirror_horiz;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  cart_bank_mapper u_cart_bank_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .cpu_en(cpu_en), .rom_addr(rom_addr), .rom_en(rom_en),
    .ram_addr(ram_addr), .ram_en(ram_en), .chr_lo_a(chr_lo_a),
    .chr_lo_b(chr_lo_b), .chr_hi_a(chr_hi_a), .chr_hi_b(chr_hi_b),
    .mirror_horiz(mirror_horiz)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpu_en = 1'b0; cpu_wr = 1'b0; cpu_addr = 16'h0000; cpu_data = 8'h00;
  endtask

  // Drive a one-cycle write on the falling edge; register loads at the next rising edge.
  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input logic en = 1'b1);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1; cpu_en = en;
    @(negedge clk);
    idle();
  endtask

  // Present a read and let combinational outputs settle before sampling.
  task automatic cpu_read(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b0; cpu_en = 1'b1; cpu_data = 8'h00;
    #1;
  endtask

  task automatic t_reset();
    cpu_read(16'h8000);
    check("R1 prg bank zero", rom_addr, 18'h00000);
    check("R1 chr_lo_a", chr_lo_a, 0);
    check("R1 chr_lo_b", chr_lo_b, 0);
    check("R1 chr_hi_a", chr_hi_a, 0);
    check("R1 chr_hi_b", chr_hi_b, 0);
    check("R1 mirror", mirror_horiz, 0);
    idle();
  endtask

  task automatic t_ram_window();
    cpu_read(16'h6000);
    check("R2 ram_en low edge", ram_en, 1);
    check("R2 ram_addr low", ram_addr, 13'h0000);
    check("R2 rom_en off in ram", rom_en, 0);
    cpu_read(16'h7ABC);
    check("R2 ram_en high edge", ram_en, 1);
    check("R2 ram_addr", ram_addr, 13'h1ABC);
    cpu_read(16'h5FFF);
    check("R2 below window", ram_en, 0);
    cpu_read(16'h8000);
    check("R2 above window", ram_en, 0);
    @(negedge clk);
    cpu_addr = 16'h6123; cpu_wr = 1'b1; cpu_en = 1'b1; #1;
    check("R2 ram_en on write", ram_en, 1);
    cpu_en = 1'b0; #1;
    check("R2 ram_en needs cpu_en", ram_en, 0);
    idle();
  endtask

  task automatic t_prg_switch();
    cpu_write(16'hA000, 8'hF5);
    cpu_read(16'h8123);
    check("R5 upper data ignored, R3 window", rom_addr, {4'h5, 14'h0123});
    check("R9 rom_en on read", rom_en, 1);
    cpu_read(16'hBFFF);
    check("R3 top of window", rom_addr, {4'h5, 14'h3FFF});
    cpu_write(16'hAFFF, 8'h0C);
    cpu_read(16'h9000);
    check("R5 any A-page address", rom_addr, {4'hC, 14'h1000});
    idle();
  endtask

  task automatic t_fixed_bank();
    cpu_read(16'hC000);
    check("R4 fixed low", rom_addr, {4'hF, 14'h0000});
    cpu_read(16'hFFFC);
    check("R4 fixed top", rom_addr, {4'hF, 14'h3FFC});
    idle();
  endtask

  task automatic t_chr_regs();
    cpu_write(16'hB000, 8'hE1);
    cpu_write(16'hC7FF, 8'h1E);
    cpu_write(16'hD555, 8'h0A);
    cpu_write(16'hEFFF, 8'hF5);
    #1;
    check("R6 chr_lo_a", chr_lo_a, 5'h01);
    check("R6 chr_lo_b", chr_lo_b, 5'h1E);
    check("R6 chr_hi_a", chr_hi_a, 5'h0A);
    check("R6 chr_hi_b", chr_hi_b, 5'h15);
  endtask

  task automatic t_mirror();
    cpu_write(16'hF000, 8'hFF);
    #1;
    check("R7 mirror set", mirror_horiz, 1);
    cpu_write(16'hFABC, 8'hFE);
    #1;
    check("R7 mirror clear, upper bits ignored", mirror_horiz, 0);
    cpu_write(16'hF001, 8'h01);
  endtask

  task automatic t_ignored_writes();
    cpu_write(16'h8000, 8'h13);
    cpu_write(16'h9FFF, 8'h1F);
    cpu_write(16'h6000, 8'h07);
    cpu_write(16'h0000, 8'h0B);
    cpu_read(16'h8000);
    check("R8 prg unchanged", rom_addr, {4'hC, 14'h0000});
    check("R8 chr_lo_a unchanged", chr_lo_a, 5'h01);
    check("R8 chr_hi_b unchanged", chr_hi_b, 5'h15);
    check("R8 mirror unchanged", mirror_horiz, 1);
    idle();
  endtask

  task automatic t_gating();
    cpu_write(16'hA000, 8'h03, 1'b0);
    cpu_write(16'hB000, 8'h1F, 1'b0);
    cpu_read(16'hB000);
    check("R10 no load without cpu_en", rom_addr, {4'hC, 14'h3000});
    check("R9 rom_en on read in B page", rom_en, 1);
    @(negedge clk); #1;
    check("R10 read does not load chr", chr_lo_a, 5'h01);
    idle();
    @(negedge clk);
    cpu_addr = 16'hC000; cpu_wr = 1'b1; cpu_en = 1'b1; cpu_data = 8'h09; #1;
    check("R9 rom_en low on write", rom_en, 0);
    check("R10 not loaded before edge", chr_lo_b, 5'h1E);
    @(posedge clk); #1;
    check("R10 loaded at edge", chr_lo_b, 5'h09);
    cpu_en = 1'b0; #1;
    check("R9 rom_en low when idle", rom_en, 0);
    idle();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_ram_window();
    t_prg_switch();
    t_fixed_bank();
    t_chr_regs();
    t_mirror();
    t_ignored_writes();
    t_gating();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule